// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block adds two 128-bit operand vectors element by element, with the element width picked on every operation. One 128-bit carry chain is built from sixteen 8-bit slices. A small decoder cuts that chain at the lane boundaries implied by the selected element width, so the same datapath serves byte, halfword, word and doubleword lanes. Every lane wraps modulo its own width, and the result bits are the same whether the lanes hold signed or unsigned data.

The operands, the element-size select and a valid strobe are presented together. The lane-wise sum and a valid flag appear on the outputs one clock later. When no valid strobe is present, the output register keeps its last result.

Top module: `simd_lane_adder`

## Requirements
- R1: With `size_sel` = 2'b00 the vector is sixteen 8-bit lanes. Lane k (bits 8k+7:8k) of `result` equals (opa lane k + opb lane k) mod 2^8.
- R2: With `size_sel` = 2'b01 the vector is eight 16-bit lanes. Lane k (bits 16k+15:16k) of `result` is the sum of the matching operand lanes mod 2^16.
- R3: With `size_sel` = 2'b10 the vector is four 32-bit lanes. Each lane of `result` is the sum of the matching operand lanes mod 2^32.
- R4: With `size_sel` = 2'b11 the vector is two 64-bit lanes. Each lane of `result` is the sum of the matching operand lanes mod 2^64.
- R5: No carry crosses a lane boundary. With all-ones operands, every lane of `result` reads all ones except bit 0, which is 0.
- R6: Inside a lane, a carry does ripple across the 8-bit slice boundaries. In 16-bit mode, 16'h00FF + 16'h0001 gives 16'h0100.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R8: While `in_valid` is low, `result` keeps its previous value, even if the operands or the select change.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and select are valid this cycle |
| size_sel | input | 2 | Element width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| out_valid | output | 1 | `result` holds a new sum |
| result | output | 128 | Registered lane-wise sum |

## Verification
The key corner case is the all-ones operand pair in every mode. A chain that is not cut at a lane edge would carry a 1 into the next lane's bit 0, and that bit would read 1 instead of 0. The opposite fault is a chain cut too often, for example one that still splits at byte boundaries in a wider mode. The 00FF + 0001 pattern catches it: a 16-bit lane then reads 0000 instead of 0100. Random operands in all four modes check that the mode decode picks the right partition. Idle cycles with changed operands check that the output register does not load when `in_valid` is low.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
    localparam int VEC_W      = 128;
    localparam int SLICE_W    = 8;
    localparam int NUM_SLICES = VEC_W / SLICE_W;

    typedef enum logic [1:0] {
        ELEM_8  = 2'b00,
        ELEM_16 = 2'b01,
        ELEM_32 = 2'b10,
        ELEM_64 = 2'b11
    } elem_size_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] sum;
    } add_state_t;
endpackage

// File: rtl/lane_cut_ctrl.sv
module lane_cut_ctrl
    import simd_add_pkg::*;
#(
    parameter int N_SLICES = NUM_SLICES
) (
    input  elem_size_e          size,
    output logic [N_SLICES-1:0] lane_start
);
    localparam int IDX_W = $clog2(N_SLICES) + 1;

    // Number of slices per lane is 2**size. A slice opens a lane when
    // its index is a multiple of that span.
    always_comb begin
        logic [IDX_W-1:0] span_mask;
        span_mask = IDX_W'((1 << size) - 1);
        for (int i = 0; i < N_SLICES; i++) begin
            lane_start[i] = ((IDX_W'(i) & span_mask) == '0);
        end
    end
endmodule

// File: rtl/byte_add_slice.sv
module byte_add_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_add_pkg::*;
#(
    parameter int DATA_W = VEC_W,
    parameter int SEG_W  = SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int N_SEG = DATA_W / SEG_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] sum;
    } stage_t;

    elem_size_e        size;
    logic [N_SEG-1:0]  lane_start;
    logic [N_SEG-1:0]  seg_cin;
    logic [N_SEG-1:0]  seg_cout;
    logic [DATA_W-1:0] raw_sum;
    logic              top_carry_unused;
    stage_t            state_d, state_q;

    assign size = elem_size_e'(size_sel);

    lane_cut_ctrl #(.N_SLICES(N_SEG)) u_cut (
        .size       (size),
        .lane_start (lane_start)
    );

    // One slice per segment; the carry into a slice is forced low at lane starts.
    for (genvar i = 0; i < N_SEG; i++) begin : g_seg
        if (i == 0) begin : g_first
            assign seg_cin[i] = 1'b0;
        end else begin : g_rest
            assign seg_cin[i] = lane_start[i] ? 1'b0 : seg_cout[i-1];
        end
        byte_add_slice #(.W(SEG_W)) u_slice (
            .a    (opa[i*SEG_W +: SEG_W]),
            .b    (opb[i*SEG_W +: SEG_W]),
            .cin  (seg_cin[i]),
            .sum  (raw_sum[i*SEG_W +: SEG_W]),
            .cout (seg_cout[i])
        );
    end

    assign top_carry_unused = seg_cout[N_SEG-1];

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.sum = raw_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.sum;

    // R1..R4: sampled lanes of each partition match a plain modulo add
    a_r1_byte_lane: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b00) |=>
            result[SEG_W-1:0] == $past(opa[SEG_W-1:0] + opb[SEG_W-1:0]));
    a_r2_half_lane: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b01) |=>
            result[31:16] == $past(opa[31:16] + opb[31:16]));
    a_r3_word_lane: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b10) |=>
            result[95:64] == $past(opa[95:64] + opb[95:64]));
    a_r4_dword_lane: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b11) |=>
            result[DATA_W-1:DATA_W-64] == $past(opa[DATA_W-1:DATA_W-64] + opb[DATA_W-1:DATA_W-64]));
    // R5: cut pattern has slice 0 as a start and one start per lane
    a_r5_lane_cuts: assert property (@(posedge clk) disable iff (rst)
        lane_start[0] && ($countones(lane_start) == (N_SEG >> size_sel)));
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));
endmodule

// File: tb/simd_lane_adder_test.sv
module simd_lane_adder_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   size_sel = 2'b00;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         out_valid;
    logic [127:0] result;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    simd_lane_adder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    function automatic logic [127:0] lane_sum(logic [127:0] a, logic [127:0] b, logic [1:0] m);
        int lw;
        logic [127:0] mask, r;
        lw = 8 << m;
        mask = (128'd1 << lw) - 128'd1;
        r = '0;
        for (int k = 0; k < 128 / lw; k++) begin
            logic [127:0] x, y;
            x = (a >> (k * lw)) & mask;
            y = (b >> (k * lw)) & mask;
            r = r | (((x + y) & mask) << (k * lw));
        end
        return r;
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check128(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // drive at negedge, the output register loads at the posedge, check at next negedge
    task automatic apply(logic [127:0] a, logic [127:0] b, logic [1:0] m, string tag);
        opa = a; opb = b; size_sel = m; in_valid = 1'b1;
        @(negedge clk);
        check1({tag, " valid"}, out_valid, 1'b1);
        check128(tag, result, lane_sum(a, b, m));
    endtask

    initial begin
        logic [127:0] held;
        void'($urandom(32'd4242));
        @(negedge clk);
        @(negedge clk);
        check1("R9 reset valid", out_valid, 1'b0);
        check128("R9 reset result", result, '0);
        rst = 1'b0;

        // R5: all-ones operands in every mode
        for (int m = 0; m < 4; m++) begin
            apply({128{1'b1}}, {128{1'b1}}, 2'(m), "R5 all-ones");
        end
        apply({128{1'b1}}, {128{1'b1}}, 2'b00, "R5 byte FE pattern");
        check128("R5 explicit", result, {16{8'hFE}});
        apply({128{1'b1}}, {128{1'b1}}, 2'b11, "R5 dword");
        check128("R5 explicit dword", result, {2{64'hFFFF_FFFF_FFFF_FFFE}});

        // R6: ripple inside a lane across slice edges
        apply({8{16'h00FF}}, {8{16'h0001}}, 2'b01, "R6 half ripple");
        check128("R6 explicit", result, {8{16'h0100}});
        apply({4{32'h00FF_FFFF}}, {4{32'h0000_0001}}, 2'b10, "R6 word ripple");
        apply({8{16'h00FF}}, {8{16'h0001}}, 2'b00, "R1 byte wrap");
        check128("R1 explicit", result, '0);

        // R1..R4: random operands in every mode
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 150; n++) begin
                apply({$urandom, $urandom, $urandom, $urandom},
                      {$urandom, $urandom, $urandom, $urandom}, 2'(m), mode_tag(2'(m)));
            end
        end

        // R7 / R8: idle cycle drops valid and keeps the result
        held = result;
        in_valid = 1'b0;
        opa = {4{32'h1234_5678}}; opb = {4{32'h9ABC_DEF0}}; size_sel = 2'b10;
        @(negedge clk);
        check1("R7 valid low", out_valid, 1'b0);
        check128("R8 hold", result, held);
        size_sel = 2'b00;
        @(negedge clk);
        check128("R8 hold again", result, held);
        apply({4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, 2'b10, "R7 valid back");

        // R9: reset in the middle of traffic
        rst = 1'b1;
        @(negedge clk);
        check1("R9 mid reset valid", out_valid, 1'b0);
        check128("R9 mid reset result", result, '0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule